// File: doc/BRIEF.md
# Indirect Branch Landing Monitor

This block watches a stream of instructions, one per valid beat, each already classified by an upstream decoder into one of a few classes: indirect call, indirect jump, landing marker (short or long form), or anything else. It checks that every indirect call or jump is followed at once by a landing marker. If the next valid instruction after an indirect branch is not a marker, the block raises a control-protection fault.

The block is a two-state tracker. It is either idle or owes a landing marker. A tracking-enable input turns the check on or off. While the check is off, markers do nothing and no fault can occur. Each fault comes out as a registered one-cycle pulse. The class and identifier of the instruction that broke the rule travel with the pulse, so the pipeline can attribute the fault.

Top module: `branch_landing_guard`

## Requirements
- R1: After synchronous reset the tracker is idle and `fault_o` is low. A reset while a marker is owed cancels the debt.
- R2: With enable high, a valid beat of class indirect call (code 1) or indirect jump (code 2) in the idle state makes the tracker owe a marker for the next valid beat.
- R3: While a marker is owed, a valid beat of class short marker (code 3) or long marker (code 4) settles the debt with no fault. Both forms count equally.
- R4: While a marker is owed, a valid non-marker beat, including another indirect branch, raises `fault_o` in the cycle after that beat. The tracker returns to idle and that beat does not arm a new debt.
- R5: Beats with `valid_i` low neither advance the tracker nor produce a fault. A debt survives any number of idle cycles.
- R6: A marker seen in the idle state is accepted silently: no fault and no change of state.
- R7: While `en_i` is low, the tracker is held idle. Branches do not arm, markers are no-ops, and `fault_o` stays low. Lowering enable while a marker is owed drops the debt.
- R8: Class code 0 means other instruction. The unused codes 5 to 7 are treated as other instructions: they fault when a marker is owed and never arm.
- R9: `fault_o` is high for exactly one cycle per offending beat. `fault_cls_o` and `fault_id_o` give that beat's class and identifier while `fault_o` is high, and hold their values until the next fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Landing tracking enable |
| valid_i | input | 1 | Instruction beat valid |
| cls_i | input | 3 | Instruction class code |
| id_i | input | ID_W | Identifier of the instruction in this beat |
| fault_o | output | 1 | Control-protection fault pulse |
| fault_cls_o | output | 3 | Class of the offending instruction |
| fault_id_o | output | ID_W | Identifier of the offending instruction |

## Verification
The only state is the one-bit debt flag, so any error in it shows at the ports within one valid beat. A debt that is lost lets a bad landing pass silently on the next valid beat. A debt that should not exist produces a `fault_o` pulse one cycle after an ordinary instruction. The tests therefore place a probe beat right after each stimulus: an ordinary instruction after markers, after disabled branches, after faults and after reset. Any debt wrongly left set then shows up as a fault one cycle later.

// File: rtl/lg_pkg.sv
package lg_pkg;
  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    INS_OTHER  = 3'd0,
    INS_ICALL  = 3'd1,
    INS_IJMP   = 3'd2,
    INS_MARK_S = 3'd3,
    INS_MARK_L = 3'd4
  } ins_cls_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_OWED = 1'b1
  } trk_st_e;
endpackage

// File: rtl/lg_classify.sv
module lg_classify
  import lg_pkg::*;
(
  input  logic [CLS_W-1:0] cls_i,
  output logic             is_branch_o,
  output logic             is_marker_o
);
  always_comb begin
    is_branch_o = 1'b0;
    is_marker_o = 1'b0;
    case (cls_i)
      INS_ICALL, INS_IJMP:     is_branch_o = 1'b1;
      INS_MARK_S, INS_MARK_L:  is_marker_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/lg_tracker.sv
module lg_tracker
  import lg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic valid_i,
  input  logic is_branch_i,
  input  logic is_marker_i,
  output logic owed_o,
  output logic fault_now_o
);
  trk_st_e st_q, st_d;

  always_comb begin
    st_d        = st_q;
    fault_now_o = 1'b0;
    if (!en_i) begin
      st_d = ST_IDLE;
    end else if (valid_i) begin
      case (st_q)
        ST_IDLE: if (is_branch_i) st_d = ST_OWED;
        ST_OWED: begin
          st_d        = ST_IDLE;
          fault_now_o = !is_marker_i;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) st_q <= ST_IDLE;
    else       st_q <= st_d;
  end

  assign owed_o = (st_q == ST_OWED);

  // R5: an invalid beat leaves the debt flag untouched while enabled
  p_hold_on_bubble_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && !valid_i) |=> $stable(st_q));

  // R7: disabled tracking always leaves the tracker idle
  p_disable_idle_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> (st_q == ST_IDLE));
endmodule

// File: rtl/lg_fault_out.sv
module lg_fault_out
  import lg_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             fault_now_i,
  input  logic [CLS_W-1:0] cls_i,
  input  logic [ID_W-1:0]  id_i,
  output logic             fault_o,
  output logic [CLS_W-1:0] fault_cls_o,
  output logic [ID_W-1:0]  fault_id_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      fault_o     <= 1'b0;
      fault_cls_o <= '0;
      fault_id_o  <= '0;
    end else begin
      fault_o <= fault_now_i;
      if (fault_now_i) begin
        fault_cls_o <= cls_i;
        fault_id_o  <= id_i;
      end
    end
  end

  // R9: the reported record is frozen between faults
  p_record_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    !fault_o |-> ($stable(fault_cls_o) && $stable(fault_id_o)) or $past(rst_i));
endmodule

// File: rtl/branch_landing_guard.sv
module branch_landing_guard
  import lg_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic             valid_i,
  input  logic [2:0]       cls_i,
  input  logic [ID_W-1:0]  id_i,
  output logic             fault_o,
  output logic [2:0]       fault_cls_o,
  output logic [ID_W-1:0]  fault_id_o
);
  logic is_branch, is_marker, owed, fault_now;

  lg_classify u_cls (
    .cls_i       (cls_i),
    .is_branch_o (is_branch),
    .is_marker_o (is_marker)
  );

  lg_tracker u_trk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .en_i        (en_i),
    .valid_i     (valid_i),
    .is_branch_i (is_branch),
    .is_marker_i (is_marker),
    .owed_o      (owed),
    .fault_now_o (fault_now)
  );

  lg_fault_out #(.ID_W(ID_W)) u_out (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .fault_now_i (fault_now),
    .cls_i       (cls_i),
    .id_i        (id_i),
    .fault_o     (fault_o),
    .fault_cls_o (fault_cls_o),
    .fault_id_o  (fault_id_o)
  );

  // R2: an enabled branch taken in idle leaves a debt behind
  p_branch_arms_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!owed && en_i && valid_i && (cls_i == 3'd1 || cls_i == 3'd2)) |=> owed);

  // R3: either marker form settles a debt without a fault
  p_marker_settles_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (owed && en_i && valid_i && (cls_i == 3'd3 || cls_i == 3'd4)) |=> (!owed && !fault_o));

  // R4: a non-marker landing faults next cycle and clears the debt
  p_bad_landing_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (owed && en_i && valid_i && cls_i != 3'd3 && cls_i != 3'd4) |=> (fault_o && !owed));

  // R6: nothing seen while idle can fault
  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    !owed |=> !fault_o);

  // R9: each pulse traces back to an enabled valid beat
  p_fault_source_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    fault_o |-> $past(valid_i && en_i));
endmodule

// File: tb/tb_branch_landing_guard.sv
module tb_branch_landing_guard;
  localparam int ID_W = 8;
  localparam int NV   = 27;

  logic            clk = 1'b0;
  logic            rst, en, valid;
  logic [2:0]      cls;
  logic [ID_W-1:0] id;
  logic            fault;
  logic [2:0]      fcls;
  logic [ID_W-1:0] fid;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #5 clk = ~clk;

  branch_landing_guard #(.ID_W(ID_W)) dut (
    .clk_i(clk), .rst_i(rst), .en_i(en), .valid_i(valid), .cls_i(cls),
    .id_i(id), .fault_o(fault), .fault_cls_o(fcls), .fault_id_o(fid)
  );

  // {req[3:0], valid, en, cls[2:0], id[7:0], expect_fault}
  localparam logic [17:0] VEC [NV] = '{
    {4'd6, 1'b1, 1'b1, 3'd0, 8'h01, 1'b0},  // R6 plain beat idle
    {4'd2, 1'b1, 1'b1, 3'd1, 8'h02, 1'b0},  // R2 call arms
    {4'd3, 1'b1, 1'b1, 3'd4, 8'h03, 1'b0},  // R3 long marker
    {4'd2, 1'b1, 1'b1, 3'd2, 8'h04, 1'b0},  // R2 jump arms
    {4'd3, 1'b1, 1'b1, 3'd3, 8'h05, 1'b0},  // R3 short marker
    {4'd6, 1'b1, 1'b1, 3'd3, 8'h06, 1'b0},  // R6 marker in idle
    {4'd6, 1'b1, 1'b1, 3'd0, 8'h07, 1'b0},  // R6 still idle
    {4'd2, 1'b1, 1'b1, 3'd2, 8'h08, 1'b0},  // R2 arm
    {4'd4, 1'b1, 1'b1, 3'd0, 8'h09, 1'b1},  // R4 bad landing
    {4'd9, 1'b1, 1'b1, 3'd0, 8'h0A, 1'b0},  // R9 single pulse, idle again
    {4'd2, 1'b1, 1'b1, 3'd1, 8'h0B, 1'b0},  // R2 arm
    {4'd5, 1'b0, 1'b1, 3'd0, 8'h0C, 1'b0},  // R5 bubble
    {4'd5, 1'b0, 1'b1, 3'd1, 8'h0D, 1'b0},  // R5 bubble with branch code
    {4'd5, 1'b1, 1'b1, 3'd4, 8'h0E, 1'b0},  // R5 debt survived, marker ok
    {4'd2, 1'b1, 1'b1, 3'd1, 8'h0F, 1'b0},  // R2 arm
    {4'd4, 1'b1, 1'b1, 3'd1, 8'h10, 1'b1},  // R4 branch as landing faults
    {4'd4, 1'b1, 1'b1, 3'd0, 8'h11, 1'b0},  // R4 faulting branch did not arm
    {4'd2, 1'b1, 1'b1, 3'd2, 8'h12, 1'b0},  // R2 arm
    {4'd7, 1'b1, 1'b0, 3'd0, 8'h13, 1'b0},  // R7 disable drops debt
    {4'd7, 1'b1, 1'b1, 3'd0, 8'h14, 1'b0},  // R7 no fault after re-enable
    {4'd7, 1'b1, 1'b0, 3'd2, 8'h15, 1'b0},  // R7 disabled jump
    {4'd7, 1'b1, 1'b1, 3'd0, 8'h16, 1'b0},  // R7 did not arm
    {4'd7, 1'b1, 1'b0, 3'd3, 8'h17, 1'b0},  // R7 marker no-op
    {4'd2, 1'b1, 1'b1, 3'd2, 8'h18, 1'b0},  // R2 arm
    {4'd8, 1'b1, 1'b1, 3'd7, 8'h19, 1'b1},  // R8 code 7 is other
    {4'd8, 1'b1, 1'b1, 3'd5, 8'h1A, 1'b0},  // R8 code 5 never arms
    {4'd8, 1'b1, 1'b1, 3'd0, 8'h1B, 1'b0}   // R8 confirm idle
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic beat(input logic v, input logic e, input logic [2:0] c, input logic [7:0] i);
    valid = v; en = e; cls = c; id = i;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; en = 1'b1; valid = 1'b0; cls = 3'd0; id = '0;
    repeat (3) @(negedge clk);
    check("R1 fault in reset", fault, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 fault after reset", fault, 0);

    for (int k = 0; k < NV; k++) begin
      logic [17:0] v;
      string tag;
      v = VEC[k];
      beat(v[13], v[12], v[11:9], v[8:1]);
      tag = $sformatf("R%0d vec%0d", v[17:14], k);
      check(tag, fault, v[0]);
      if (v[0]) begin
        check({tag, " cls"}, fcls, v[11:9]);
        check({tag, " id"}, fid, v[8:1]);
      end
    end

    // R9: record held after pulse ends (last fault was code 7, id 0x19)
    check("R9 held cls", fcls, 3'd7);
    check("R9 held id", fid, 8'h19);

    // R1: reset while owed cancels the debt
    beat(1'b1, 1'b1, 3'd1, 8'h30);
    valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    beat(1'b1, 1'b1, 3'd0, 8'h31);
    check("R1 debt cleared by reset", fault, 0);

    // R4/R9: two faults in a row on consecutive debts
    beat(1'b1, 1'b1, 3'd2, 8'h40);
    beat(1'b1, 1'b1, 3'd0, 8'h41);
    check("R4 first fault", fault, 1);
    check("R9 first id", fid, 8'h41);
    beat(1'b1, 1'b1, 3'd1, 8'h42);
    check("R9 pulse ends", fault, 0);
    beat(1'b1, 1'b1, 3'd6, 8'h43);
    check("R8 code 6 faults", fault, 1);
    check("R9 second cls", fcls, 3'd6);
    check("R9 second id", fid, 8'h43);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule